// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch Controller

This block is the slave-side command front end of a serial flash device. It watches a four-wire serial port (select, clock, data in, data out) and collects the first eight bits of each select frame, most significant bit first, into an instruction byte. It keeps the single write-enable latch bit. That bit guards the four instructions that modify the device: page program, sector erase, bulk erase and status write.

An enable instruction sets the latch and a disable instruction clears it. Each one acts only when select returns high after exactly eight clocked bits. A modify instruction that arrives while the latch is set, and no operation is in progress, raises a one-cycle start pulse with a kind code and sets a busy flag. A stubbed operation engine later returns a done pulse, which clears both busy and the latch. While busy, every instruction is ignored. A modify instruction that arrives with the latch clear is dropped.

The serial inputs are asynchronous to the system clock. They are resynchronised and edge-detected inside the block, so the serial clock must run well below the system clock. The data output is never driven by this block.

Top module: `wel_ctrl`

## Requirements
- R1: Synchronous active-high reset `rst` clears `wel` and `busy`, and no start pulse is raised while it is asserted or on the cycle after.
- R2: The enable opcode 0x06 sets `wel` when `spi_cs_n` rises after exactly eight bits were sampled on rising `spi_sclk` edges (mode 0, MSB first).
- R3: The disable opcode 0x04, framed by exactly eight bits, clears `wel` when `spi_cs_n` rises.
- R4: An enable or disable frame with a bit count other than eight leaves `wel` unchanged.
- R5: With `wel`=1 and `busy`=0, a modify opcode raises `start_valid` for one cycle once its eighth bit is sampled, and `busy` is set from the next cycle. The modify opcodes are 0x02, 0xD8, 0xC7 and 0x01, and `start_kind` is 0, 1, 2 or 3 for them in that order. A frame shorter than eight bits starts nothing.
- R6: A modify opcode received while `wel`=0 raises no start pulse and leaves `busy` at 0.
- R7: `op_done` while `busy`=1 clears both `busy` and `wel` on the next cycle. `op_done` while `busy`=0 has no effect.
- R8: While `busy`=1, enable, disable and modify instructions have no effect on `wel`, `busy` or `start_valid`.
- R9: `spi_miso_oe` is always 0, so the data output stays high impedance, and `spi_miso` is 0.
- R10: An opcode outside the six listed has no effect on `wel`, `busy` or `start_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial data out of the device (held at 0) |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (held at 0) |
| op_done | input | 1 | One-cycle completion pulse from the operation engine |
| start_valid | output | 1 | One-cycle pulse for an accepted modify instruction |
| start_kind | output | 2 | Kind of accepted modify: 0 program, 1 sector, 2 bulk, 3 status |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Modify operation in progress |

## Verification
The bench builds the block with the default two synchroniser stages and runs the serial clock at one eighth of the system clock. That ratio lets every select edge and serial clock edge cross the synchroniser cleanly. It also lets each frame's result be sampled at a fixed, known distance after select rises. The frames it sends have seven, eight or nine bits, so the exact-count rule is exercised on both sides. The bench also reaches the busy window between a start pulse and its done pulse, including instructions sent inside it, and a reset applied while the latch is set and while an operation is running.

// File: rtl/wel_pkg.sv
package wel_pkg;

    localparam int OPC_W = 8;

    typedef logic [OPC_W-1:0] opcode_t;

    localparam opcode_t OPC_ENABLE  = 8'h06;
    localparam opcode_t OPC_DISABLE = 8'h04;
    localparam opcode_t OPC_PROGRAM = 8'h02;
    localparam opcode_t OPC_SECTOR  = 8'hD8;
    localparam opcode_t OPC_BULK    = 8'hC7;
    localparam opcode_t OPC_STATUS  = 8'h01;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_ENABLE  = 2'd1,
        CLS_DISABLE = 2'd2,
        CLS_MODIFY  = 2'd3
    } cmd_class_e;

    typedef enum logic [1:0] {
        MOD_PROGRAM = 2'd0,
        MOD_SECTOR  = 2'd1,
        MOD_BULK    = 2'd2,
        MOD_STATUS  = 2'd3
    } mod_kind_e;

    typedef struct packed {
        cmd_class_e cls;
        mod_kind_e  kind;
    } cmd_t;

    // Events produced by the serial receiver, one cycle wide.
    typedef struct packed {
        logic    opc_valid;   // eighth bit just sampled
        opcode_t opc;         // first byte of the current / last frame
        logic    frame_end;   // select returned high
        logic    exact;       // frame_end after exactly OPC_W bits
    } rx_evt_t;

    function automatic cmd_t classify(opcode_t op);
        cmd_t c;
        c.cls  = CLS_NONE;
        c.kind = MOD_PROGRAM;
        case (op)
            OPC_ENABLE:  c.cls = CLS_ENABLE;
            OPC_DISABLE: c.cls = CLS_DISABLE;
            OPC_PROGRAM: begin c.cls = CLS_MODIFY; c.kind = MOD_PROGRAM; end
            OPC_SECTOR:  begin c.cls = CLS_MODIFY; c.kind = MOD_SECTOR;  end
            OPC_BULK:    begin c.cls = CLS_MODIFY; c.kind = MOD_BULK;    end
            OPC_STATUS:  begin c.cls = CLS_MODIFY; c.kind = MOD_STATUS;  end
            default:     c.cls = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wel_sync.sv
module wel_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wel_spi_rx.sv
module wel_spi_rx
    import wel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n_s,
    input  logic    sclk_s,
    input  logic    mosi_s,
    output rx_evt_t evt
);
    localparam int CNT_W = $clog2(OPC_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPC_W - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OPC_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(OPC_W + 1);

    logic             sclk_q, cs_q;
    logic             sclk_rise, cs_rise;
    logic [CNT_W-1:0] cnt;
    logic [OPC_W-1:0] shreg;
    logic [OPC_W-1:0] next_byte;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign cs_rise   = cs_n_s & ~cs_q;
    assign next_byte = {shreg[OPC_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            cs_q   <= cs_n_s;
        end
    end

    // bit counter saturates one past a full byte so longer frames stay distinguishable
    always_ff @(posedge clk) begin
        if (rst || cs_n_s)
            cnt <= '0;
        else if (sclk_rise && cnt != CNT_OVER)
            cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (sclk_rise && !cs_n_s && cnt < CNT_FULL)
            shreg <= next_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt.opc_valid <= sclk_rise && !cs_n_s && (cnt == CNT_LAST);
            if (sclk_rise && !cs_n_s && (cnt == CNT_LAST))
                evt.opc <= next_byte;
            evt.frame_end <= cs_rise;
            evt.exact     <= cs_rise && (cnt == CNT_FULL);
        end
    end
endmodule

// File: rtl/wel_decode.sv
module wel_decode
    import wel_pkg::*;
(
    input  rx_evt_t evt,
    output cmd_t    cmd
);
    always_comb cmd = classify(evt.opc);
endmodule

// File: rtl/wel_state.sv
module wel_state
    import wel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_evt_t   evt,
    input  cmd_t      cmd,
    input  logic      op_done,
    output logic      wel,
    output logic      busy,
    output logic      start_valid,
    output mod_kind_e start_kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wel         <= 1'b0;
            busy        <= 1'b0;
            start_valid <= 1'b0;
            start_kind  <= MOD_PROGRAM;
        end else begin
            start_valid <= 1'b0;
            if (busy) begin
                if (op_done) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                end
            end else begin
                if (evt.opc_valid && cmd.cls == CLS_MODIFY && wel) begin
                    start_valid <= 1'b1;
                    start_kind  <= cmd.kind;
                    busy        <= 1'b1;
                end
                if (evt.frame_end && evt.exact) begin
                    case (cmd.cls)
                        CLS_ENABLE:  wel <= 1'b1;
                        CLS_DISABLE: wel <= 1'b0;
                        default:     ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wel_ctrl.sv
module wel_ctrl
    import wel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic       op_done,
    output logic       start_valid,
    output logic [1:0] start_kind,
    output logic       wel,
    output logic       busy
);
    logic [2:0] pins_s;
    rx_evt_t    evt;
    cmd_t       cmd;
    mod_kind_e  kind;
    logic       frame_ok;

    wel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sclk, spi_mosi}),
        .q   (pins_s)
    );

    wel_spi_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (pins_s[2]),
        .sclk_s (pins_s[1]),
        .mosi_s (pins_s[0]),
        .evt    (evt)
    );

    wel_decode u_dec (
        .evt (evt),
        .cmd (cmd)
    );

    wel_state u_st (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .cmd         (cmd),
        .op_done     (op_done),
        .wel         (wel),
        .busy        (busy),
        .start_valid (start_valid),
        .start_kind  (kind)
    );

    assign frame_ok    = evt.frame_end & evt.exact;
    assign start_kind  = kind;
    assign spi_miso    = 1'b0;
    assign spi_miso_oe = 1'b0;
endmodule

// File: rtl/wel_ctrl_chk.sv
module wel_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic wel,
    input logic busy,
    input logic start_valid,
    input logic op_done,
    input logic spi_miso_oe,
    input logic frame_ok
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!wel && !busy && !start_valid)); // R1
    AST_WEL_SET_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> $past(frame_ok)); // R2
    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (wel && $past(wel) && !$past(busy))); // R6
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> busy); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_done && busy) |=> (!wel && !busy)); // R7
    AST_BUSY_HOLDS_WEL: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_done) |=> ($stable(wel) && busy && !start_valid)); // R8
    AST_OE_LOW: assert property (@(posedge clk) !spi_miso_oe); // R9
endmodule

bind wel_ctrl wel_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wel         (wel),
    .busy        (busy),
    .start_valid (start_valid),
    .op_done     (op_done),
    .spi_miso_oe (spi_miso_oe),
    .frame_ok    (frame_ok)
);

// File: tb/tb_wel_ctrl.sv
module tb_wel_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       op_done = 1'b0;
    logic       spi_miso, spi_miso_oe, start_valid, wel, busy;
    logic [1:0] start_kind;

    int checks = 0;
    int fails  = 0;
    int starts = 0;
    int oe_bad = 0;
    logic [1:0] last_kind = 2'd0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wel_ctrl dut (
        .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .op_done(op_done), .start_valid(start_valid), .start_kind(start_kind),
        .wel(wel), .busy(busy)
    );

    always @(posedge clk) begin
        if (start_valid) begin
            starts    <= starts + 1;
            last_kind <= start_kind;
        end
        if (spi_miso_oe || spi_miso) oe_bad <= oe_bad + 1;
    end

    // vector: opcode, bit count (0 = no frame), done pulse after frame,
    //         expected wel, busy, start delta, requirement number
    localparam int NV = 25;
    localparam logic [19:0] VEC [NV] = '{
        {8'h02, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
        {8'h04, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        {8'h04, 4'd9, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},
        {8'h04, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        {8'h06, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        {8'h06, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'hD8, 4'd8, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
        {8'h04, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},  // R8
        {8'hC7, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b1, 1'b0, 4'd8},
        {8'h00, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'hC7, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'h01, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'h02, 4'd8, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        {8'h06, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},
        {8'h9F, 4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10}, // R10
        {8'h00, 4'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},
        {8'h02, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},
        {8'h04, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
        {8'hC7, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6}
    };

    function automatic logic [1:0] kind_of(logic [7:0] op);
        case (op)
            8'h02:   return 2'd0;
            8'hD8:   return 2'd1;
            8'hC7:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic frame(logic [7:0] op, int nbits);
        spi_cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 8) ? op[7-i] : 1'b0;
            tick(4);
            spi_sclk = 1'b1;
            tick(4);
            spi_sclk = 1'b0;
        end
        tick(4);
        spi_cs_n = 1'b1;
        tick(10);
    endtask

    task automatic pulse_done();
        op_done = 1'b1;
        tick(1);
        op_done = 1'b0;
        tick(4);
    endtask

    initial begin
        tick(5);
        // R1: state held by reset
        check("R1 wel", wel, 0);
        check("R1 busy", busy, 0);
        check("R1 start", start_valid, 0);
        rst = 1'b0;
        tick(5);
        check("R1 wel after release", wel, 0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] op;
            int nb;
            int s0;
            string tag;
            op  = VEC[v][19:12];
            nb  = int'(VEC[v][11:8]);
            s0  = starts;
            tag = $sformatf("R%0d vec%0d", VEC[v][3:0], v);
            if (nb != 0) frame(op, nb);
            if (VEC[v][7]) pulse_done();
            check({tag, " wel"}, wel, VEC[v][6]);
            check({tag, " busy"}, busy, VEC[v][5]);
            check({tag, " starts"}, starts - s0, VEC[v][4]);
            if (VEC[v][4]) check({tag, " kind"}, last_kind, kind_of(op));
        end

        // R1: reset with latch set
        frame(8'h06, 8);
        check("R2 wel before reset", wel, 1);
        rst = 1'b1; tick(3); rst = 1'b0; tick(3);
        check("R1 wel cleared by reset", wel, 0);

        // R1: reset while an operation is running
        frame(8'h06, 8);
        frame(8'hD8, 8);
        check("R5 busy before reset", busy, 1);
        rst = 1'b1; tick(3); rst = 1'b0; tick(3);
        check("R1 busy cleared by reset", busy, 0);
        check("R1 wel cleared with busy", wel, 0);

        // R9: data output never driven
        check("R9 miso/oe activity", oe_bad, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule